// File: doc/BRIEF.md
# Three-Wire Serial Register Slave

This block is the slave end of a three-wire serial register bus. The bus has a serial clock, a strobe and a single data line that both sides share. The master shifts an 8-bit address into the slave while the strobe is low. To write, it then shifts in a data byte and pulses the strobe. To read, it pulses the strobe right after the address. When the strobe falls, the slave takes over the data line and shifts out the addressed byte, then releases the line to the master.

All three pad inputs are first synchronised into the system clock domain. Each transaction is decoded from edges of the synchronised signals. The register storage sits outside the block, behind a simple interface: the block gives a write strobe with address and data, and takes back read data that depends only on the presented address. An input mask marks reserved addresses. Any address at or above the map size also counts as reserved. The pad tristate cell is outside the block; it is driven by a data-out and an output-enable pair.

Top module: `sreg3w_slave`

## Requirements
- R1: While the strobe is low and the line is not being driven, each rising edge of the serial clock shifts in one bit from the data pad. Bits arrive most significant first. The first eight bits form the address and the next eight form the data byte.
- R2: A rising strobe after exactly 16 received bits to a non-reserved address gives a one-cycle `rf_we` pulse. During that pulse, `rf_addr` is the first byte and `rf_wdata` is the second byte.
- R3: A rising strobe after any bit count other than 8 or 16 discards the frame. No write happens, and the next strobe fall does not drive the line.
- R4: A rising strobe after exactly 8 received bits to a non-reserved address arms a read. On the next strobe fall, `sdo_oe` rises and `sdo_pad` carries bit 7 of the addressed register.
- R5: While driving, each falling edge of the serial clock presents the next lower bit. Bits 6 down to 0 appear on the first through seventh falls.
- R6: On the eighth falling serial-clock edge of a read, `sdo_oe` returns low. The block then waits for a new address.
- R7: A read of a reserved address never raises `sdo_oe`.
- R8: A write to a reserved address produces no `rf_we` pulse.
- R9: Serial-clock and data activity while the strobe is high leaves the receive state untouched.
- R10: A synchronous reset forces `sdo_oe` low, clears the bit count and drops any armed read, including in the middle of a read.
- R11: Any address greater than or equal to the map size `NREG` is reserved for both reads and writes.
- R12: A strobe rise during a read ends the read. `sdo_oe` is low after the event passes through the synchroniser.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_pad | input | 1 | Serial clock from the pad |
| stb_pad | input | 1 | Strobe from the pad |
| sdi_pad | input | 1 | Data line input buffer |
| sdo_pad | output | 1 | Data line output value |
| sdo_oe | output | 1 | Data line output enable |
| rf_we | output | 1 | Register write strobe, one cycle |
| rf_addr | output | 8 | Register address |
| rf_wdata | output | 8 | Register write data |
| rf_rdata | input | 8 | Register read data for `rf_addr` |
| rsvd_mask | input | NREG | One bit per address, set means reserved |

## Verification
The assertions assume the following about the master:
- Each pad level is held for at least two system clocks, so every edge shows up exactly once after synchronisation.
- The serial clock is never toggled in the same synchronised cycle as a strobe edge.
- `rsvd_mask` and the register contents change only while the bus is idle.

The stimulus keeps every pad level constant for four system clocks. It moves the strobe only while the serial clock is low, and it never changes the mask. Within those rules, it deliberately toggles the serial clock while the strobe is high, sends short and long frames, and aborts a read with the strobe and with reset.

// File: rtl/sreg3w_pkg.sv
package sreg3w_pkg;
    localparam int BYTE_W  = 8;
    localparam int FRAME_W = 2 * BYTE_W;
    localparam int CNT_W   = $clog2(FRAME_W + 2);

    typedef enum logic [1:0] {
        FRM_SHORT,
        FRM_ADDR,
        FRM_FULL
    } frm_kind_e;

    typedef struct packed {
        logic lvl;
        logic rise;
        logic fall;
    } pin_ev_t;

    function automatic frm_kind_e classify(input logic [CNT_W-1:0] n);
        if (n == CNT_W'(BYTE_W))       return FRM_ADDR;
        else if (n == CNT_W'(FRAME_W)) return FRM_FULL;
        else                           return FRM_SHORT;
    endfunction
endpackage

// File: rtl/sreg3w_sync.sv
module sreg3w_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;

    for (genvar g = 0; g < W; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q[g] <= 1'b0;
                q_o[g]    <= 1'b0;
            end else begin
                meta_q[g] <= d_i[g];
                q_o[g]    <= meta_q[g];
            end
        end
    end
endmodule

// File: rtl/sreg3w_rx.sv
module sreg3w_rx
    import sreg3w_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               shift_i,
    input  logic               clr_i,
    input  logic               bit_i,
    output logic [FRAME_W-1:0] frm_o,
    output logic [CNT_W-1:0]   cnt_o
);
    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(FRAME_W + 1);

    // R1: MSB-first shift; the count saturates so that over-long frames stay invalid
    always_ff @(posedge clk) begin
        if (rst) begin
            frm_o <= '0;
            cnt_o <= '0;
        end else if (clr_i) begin
            cnt_o <= '0;
        end else if (shift_i) begin
            frm_o <= {frm_o[FRAME_W-2:0], bit_i};
            if (cnt_o != CNT_SAT) cnt_o <= cnt_o + 1'b1;
        end
    end
endmodule

// File: rtl/sreg3w_tx.sv
module sreg3w_tx
    import sreg3w_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              abort_i,
    input  logic              load_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              step_i,
    output logic              sdo_o,
    output logic              oe_o
);
    localparam int OC_W = $clog2(BYTE_W);

    logic [BYTE_W-1:0] sh_q;
    logic [OC_W-1:0]   oc_q;

    always_ff @(posedge clk) begin
        if (rst || abort_i) begin
            oe_o  <= 1'b0;
            sdo_o <= 1'b0;
            sh_q  <= '0;
            oc_q  <= '0;
        end else if (load_i) begin
            oe_o  <= 1'b1;
            sdo_o <= byte_i[BYTE_W-1];
            sh_q  <= byte_i;
            oc_q  <= '0;
        end else if (step_i && oe_o) begin
            if (oc_q == OC_W'(BYTE_W - 1)) begin
                oe_o  <= 1'b0;
                sdo_o <= 1'b0;
            end else begin
                sdo_o <= sh_q[BYTE_W-2];
                sh_q  <= {sh_q[BYTE_W-2:0], 1'b0};
                oc_q  <= oc_q + 1'b1;
            end
        end
    end

    // R5
    sdo_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (oe_o && $past(oe_o) && !$past(step_i) && !$past(load_i)) |-> $stable(sdo_o));
endmodule

// File: rtl/sreg3w_slave.sv
module sreg3w_slave
    import sreg3w_pkg::*;
#(
    parameter int NREG = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_pad,
    input  logic              stb_pad,
    input  logic              sdi_pad,
    output logic              sdo_pad,
    output logic              sdo_oe,
    output logic              rf_we,
    output logic [BYTE_W-1:0] rf_addr,
    output logic [BYTE_W-1:0] rf_wdata,
    input  logic [BYTE_W-1:0] rf_rdata,
    input  logic [NREG-1:0]   rsvd_mask
);
    localparam int AIDX = (NREG > 1) ? $clog2(NREG) : 1;

    logic [2:0]         pin_s;
    logic [1:0]         prev_q;
    pin_ev_t            sclk_ev, stb_ev;
    logic               sdi_s;
    logic [FRAME_W-1:0] frm;
    logic [CNT_W-1:0]   cnt;
    logic               armed_q;
    logic               rx_shift, tx_step, tx_load;
    frm_kind_e          kind;
    logic [BYTE_W-1:0]  cand_addr;

    // R11: out-of-range addresses count as reserved
    function automatic logic is_rsvd(input logic [BYTE_W-1:0] a, input logic [NREG-1:0] m);
        if (int'(a) >= NREG) return 1'b1;
        return m[a[AIDX-1:0]];
    endfunction

    sreg3w_sync #(.W(3)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i ({sdi_pad, stb_pad, sclk_pad}),
        .q_o (pin_s)
    );

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= pin_s[1:0];
    end

    always_comb begin
        sclk_ev = '{lvl: pin_s[0], rise: pin_s[0] & ~prev_q[0], fall: ~pin_s[0] & prev_q[0]};
        stb_ev  = '{lvl: pin_s[1], rise: pin_s[1] & ~prev_q[1], fall: ~pin_s[1] & prev_q[1]};
        sdi_s   = pin_s[2];
    end

    // R9: the serial clock only acts while the strobe is low
    assign rx_shift = !stb_ev.lvl && sclk_ev.rise && !sdo_oe;
    assign tx_step  = !stb_ev.lvl && sclk_ev.fall;
    assign tx_load  = stb_ev.fall && armed_q;
    assign kind     = classify(cnt);
    assign cand_addr = (kind == FRM_FULL) ? frm[FRAME_W-1:BYTE_W] : frm[BYTE_W-1:0];

    sreg3w_rx u_rx (
        .clk     (clk),
        .rst     (rst),
        .shift_i (rx_shift),
        .clr_i   (stb_ev.rise),
        .bit_i   (sdi_s),
        .frm_o   (frm),
        .cnt_o   (cnt)
    );

    // R2 R3 R4 R7 R8: frame decode on the strobe rise
    always_ff @(posedge clk) begin
        if (rst) begin
            rf_we    <= 1'b0;
            rf_addr  <= '0;
            rf_wdata <= '0;
            armed_q  <= 1'b0;
        end else begin
            rf_we <= 1'b0;
            if (stb_ev.rise) begin
                armed_q <= 1'b0;
                if (kind != FRM_SHORT) rf_addr <= cand_addr;
                if (kind == FRM_FULL && !is_rsvd(cand_addr, rsvd_mask)) begin
                    rf_we    <= 1'b1;
                    rf_wdata <= frm[BYTE_W-1:0];
                end
                if (kind == FRM_ADDR && !is_rsvd(cand_addr, rsvd_mask)) armed_q <= 1'b1;
            end else if (stb_ev.fall) begin
                armed_q <= 1'b0;
            end
        end
    end

    sreg3w_tx u_tx (
        .clk     (clk),
        .rst     (rst),
        .abort_i (stb_ev.rise),
        .load_i  (tx_load),
        .byte_i  (rf_rdata),
        .step_i  (tx_step),
        .sdo_o   (sdo_pad),
        .oe_o    (sdo_oe)
    );

    // R10
    reset_release_chk: assert property (@(posedge clk) rst |=> !sdo_oe);
    // R2
    we_single_chk: assert property (@(posedge clk) disable iff (rst) rf_we |=> !rf_we);
    // R8
    we_not_rsvd_chk: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> !is_rsvd(rf_addr, rsvd_mask));
    // R4
    oe_on_stb_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sdo_oe) |-> $past(stb_ev.fall));
    // R12
    stb_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (stb_ev.rise && sdo_oe) |=> !sdo_oe);
    // R9
    frame_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (stb_ev.lvl && $past(stb_ev.lvl)) |-> $stable(frm));
endmodule

// File: tb/test_sreg3w_slave.sv
module test_sreg3w_slave;
    localparam int NREG = 16;
    localparam logic [NREG-1:0] MASK = 16'h0020;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk_pad = 1'b0, stb_pad = 1'b0, sdi_pad = 1'b0;
    logic sdo_pad, sdo_oe, rf_we;
    logic [7:0] rf_addr, rf_wdata, rf_rdata;
    logic [7:0] bmem [NREG];

    int n_cmp = 0, n_bad = 0, cyc = 0, we_seen = 0;

    always #4 clk = ~clk;

    assign rf_rdata = (int'(rf_addr) < NREG) ? bmem[rf_addr[3:0]] : 8'h00;

    sreg3w_slave #(.NREG(NREG)) i_sreg3w_slave (
        .clk(clk), .rst(rst), .sclk_pad(sclk_pad), .stb_pad(stb_pad), .sdi_pad(sdi_pad),
        .sdo_pad(sdo_pad), .sdo_oe(sdo_oe), .rf_we(rf_we), .rf_addr(rf_addr),
        .rf_wdata(rf_wdata), .rf_rdata(rf_rdata), .rsvd_mask(MASK)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // behavioural reference model
    int m_p1 [3], m_p2 [3], m_p3 [2];
    int m_cnt, m_frm, m_armed, m_oe, m_sdo, m_sh, m_oc, m_we, m_addr, m_wd;
    int mmem [NREG];

    function automatic bit m_rsvd(int a);
        return (a >= NREG) || MASK[a % NREG];
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (rf_we && int'(rf_addr) < NREG) bmem[rf_addr[3:0]] <= rf_wdata;
        if (rf_we) we_seen++;
        if (rst) begin
            m_p1 = '{0, 0, 0}; m_p2 = '{0, 0, 0}; m_p3 = '{0, 0};
            m_cnt = 0; m_frm = 0; m_armed = 0; m_oe = 0; m_sdo = 0; m_sh = 0;
            m_oc = 0; m_we = 0; m_addr = 0; m_wd = 0;
        end else begin
            int cand;
            bit sr, sf, tr, tf;
            sr = m_p2[0] && !m_p3[0]; sf = !m_p2[0] && m_p3[0];
            tr = m_p2[1] && !m_p3[1]; tf = !m_p2[1] && m_p3[1];
            m_we = 0;
            if (tr) begin
                cand = (m_cnt == 16) ? (m_frm >> 8) & 255 : m_frm & 255;
                if (m_cnt == 8 || m_cnt == 16) m_addr = cand;
                if (m_cnt == 16 && !m_rsvd(cand)) begin
                    m_we = 1; m_wd = m_frm & 255; mmem[cand] = m_wd;
                end
                m_armed = (m_cnt == 8 && !m_rsvd(cand));
                m_cnt = 0;
                m_oe = 0; m_sdo = 0;
            end else if (tf) begin
                if (m_armed) begin
                    m_sh = (m_addr < NREG) ? mmem[m_addr] : 0;
                    m_oe = 1; m_sdo = (m_sh >> 7) & 1; m_oc = 0;
                end
                m_armed = 0;
            end else if (!m_p2[1] && sf && m_oe) begin
                if (m_oc == 7) begin m_oe = 0; m_sdo = 0; end
                else begin m_oc++; m_sdo = (m_sh >> (7 - m_oc)) & 1; end
            end else if (!m_p2[1] && sr && !m_oe) begin
                m_frm = ((m_frm << 1) | m_p2[2]) & 16'hFFFF;
                if (m_cnt != 17) m_cnt++;
            end
            m_p3[0] = m_p2[0]; m_p3[1] = m_p2[1];
            m_p2 = m_p1;
            m_p1 = '{int'(sclk_pad), int'(stb_pad), int'(sdi_pad)};
        end
    end

    // R1/R2/R4/R5/R6: per-cycle comparison with the model
    always @(negedge clk) begin
        if (!rst) begin
            check(sdo_oe == m_oe[0], "R4/R6 oe vs model", sdo_oe, m_oe);
            if (m_oe != 0) check(sdo_pad == m_sdo[0], "R5 sdo vs model", sdo_pad, m_sdo);
            check(rf_we == m_we[0], "R2/R8 we vs model", rf_we, m_we);
            if (m_we != 0) begin
                check(rf_addr == 8'(m_addr), "R2 addr vs model", rf_addr, m_addr);
                check(rf_wdata == 8'(m_wd), "R2 data vs model", rf_wdata, m_wd);
            end
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bits(input logic [15:0] v, input int nb);
        for (int i = nb - 1; i >= 0; i--) begin
            sdi_pad = v[i]; sclk_pad = 1'b0; wait_n(4);
            sclk_pad = 1'b1; wait_n(4);
            sclk_pad = 1'b0;
        end
        wait_n(4);
    endtask

    task automatic strobe();
        stb_pad = 1'b1; wait_n(4);
        stb_pad = 1'b0; wait_n(4);
    endtask

    task automatic write(input logic [7:0] a, input logic [7:0] d);
        send_bits({a, d}, 16);
        strobe();
    endtask

    task automatic read(input logic [7:0] a, output logic [7:0] got, output bit drove);
        send_bits({8'h00, a}, 8);
        strobe();
        drove = sdo_oe;
        got = '0;
        got[7] = sdo_pad;
        for (int i = 6; i >= -1; i--) begin
            sclk_pad = 1'b1; wait_n(4);
            sclk_pad = 1'b0; wait_n(4);
            if (i >= 0) got[i] = sdo_pad;
        end
    endtask

    initial begin
        for (int i = 0; i < NREG; i++) begin
            bmem[i] = 8'(i * 29 + 7);
            mmem[i] = i * 29 + 7;
        end
    end

    initial begin
        logic [7:0] got;
        bit drove;
        int w0;
        wait_n(3);
        // R10: reset state
        check(sdo_oe == 1'b0, "R10 oe in reset", sdo_oe, 0);
        check(rf_we == 1'b0, "R10 we in reset", rf_we, 0);
        rst = 1'b0;
        wait_n(2);

        // R1 R2: full write, then R4 R5 R6 readback
        w0 = we_seen;
        write(8'h03, 8'hA5);
        check(we_seen == w0 + 1, "R2 one write pulse", we_seen - w0, 1);
        read(8'h03, got, drove);
        check(drove, "R4 line driven on read", drove, 1);
        check(got == 8'hA5, "R5 read byte", got, 8'hA5);
        check(sdo_oe == 1'b0, "R6 released after 8 falls", sdo_oe, 0);

        // untouched register, different pattern
        read(8'h0C, got, drove);
        check(got == 8'(12 * 29 + 7), "R1 read init value", got, 8'(12 * 29 + 7));

        // R8 R7: reserved address 5
        w0 = we_seen;
        write(8'h05, 8'h11);
        check(we_seen == w0, "R8 reserved write ignored", we_seen - w0, 0);
        read(8'h05, got, drove);
        check(!drove && sdo_oe == 1'b0, "R7 reserved read not driven", drove, 0);

        // R11: out of range
        w0 = we_seen;
        write(8'hC8, 8'h77);
        check(we_seen == w0, "R11 out-of-range write ignored", we_seen - w0, 0);
        read(8'hC8, got, drove);
        check(!drove, "R11 out-of-range read not driven", drove, 0);

        // R3: 12-bit frame discarded
        w0 = we_seen;
        send_bits(16'h03F, 12);
        strobe();
        check(we_seen == w0 && sdo_oe == 1'b0, "R3 partial frame discarded", we_seen - w0, 0);
        read(8'h03, got, drove);
        check(got == 8'hA5, "R3 register unchanged", got, 8'hA5);

        // R9: clock and data toggled while strobe high
        stb_pad = 1'b1; wait_n(4);
        for (int k = 0; k < 4; k++) begin
            sdi_pad = 1'b1; sclk_pad = 1'b1; wait_n(4);
            sclk_pad = 1'b0; wait_n(4);
        end
        stb_pad = 1'b0; wait_n(4);
        write(8'h02, 8'h3C);
        read(8'h02, got, drove);
        check(got == 8'h3C, "R9 strobe-high activity ignored", got, 8'h3C);

        // R12: strobe rise aborts a read
        send_bits(16'h0009, 8);
        strobe();
        check(sdo_oe == 1'b1, "R12 read started", sdo_oe, 1);
        sclk_pad = 1'b1; wait_n(4); sclk_pad = 1'b0; wait_n(4);
        stb_pad = 1'b1; wait_n(4);
        check(sdo_oe == 1'b0, "R12 released by strobe", sdo_oe, 0);
        stb_pad = 1'b0; wait_n(4);
        check(sdo_oe == 1'b0, "R12 stays released", sdo_oe, 0);

        // R10: reset during a read
        send_bits(16'h0003, 8);
        strobe();
        check(sdo_oe == 1'b1, "R10 read started", sdo_oe, 1);
        rst = 1'b1; wait_n(2);
        check(sdo_oe == 1'b0, "R10 reset releases line", sdo_oe, 0);
        rst = 1'b0; wait_n(4);
        read(8'h03, got, drove);
        check(got == 8'hA5, "R10 clean after reset", got, 8'hA5);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule